// File: doc/BRIEF.md
# Eight-Channel DAC Command and Register Core

This block is the digital heart of an eight-channel voltage DAC. A serial front end (not part of this block) assembles 32-bit command words and presents each one with a one-cycle valid strobe. While it shifts a word in, it also raises a flag that says a write is in progress. The core decodes each word and keeps the state for every channel: an input register, a DAC register and a power-down mode. It also keeps a shared internal-reference enable and a two-bit clear-code register.

Two pins act outside the command stream. The first is an active-low transfer level. While it is low, every DAC register follows its input register. The second is an asynchronous active-low preset. A falling edge on it is brought into the clock domain through a two-flop synchroniser and an edge detector. It then loads every register with a zero, mid or full-scale code, and it aborts any command that is being shifted at that moment.

The outputs are one code per channel, one two-bit drive mode per channel and the reference enable. A channel that is powered down presents code zero on its code output. The analog stage reads the drive mode to learn how the pin is terminated.

Top module: `dac_ctrl_core`

## Requirements
- R1: After reset, every channel code is 0x0000, every drive mode is 00 (normal), the reference is off and the clear code selects zero scale.
- R2: The word fields are command [27:24], address [23:20] and data [19:4]. Address 0 to 7 selects one channel and address 1111 selects all channels. Command 0000 writes the input register. Command 0001 copies the input register into the DAC register. Command 0011 writes both registers. With transfer high, only the DAC register drives the channel code.
- R3: While the transfer input is low, each DAC register takes its input register's new value on the same clock edge that writes the input register.
- R4: Command 0100 writes the mode in bits [9:8] to every channel whose bit is 1 in the mask [7:0]. Bit 0 of the mask is channel 0. The mode codes are 00 normal, 01 1 k to ground, 10 100 k to ground and 11 three-state. A channel in any mode other than 00 outputs code 0x0000.
- R5: Power-down leaves the DAC register unchanged. When a channel powers back up with transfer high, it shows the DAC register value from before the power-down. With transfer low, it shows its input register.
- R6: Command 1000 sets the reference enable to bit 0 of the word. All other bits are don't care.
- R7: The reference output is on only when the reference enable is set and at least one channel is in mode 00.
- R8: Command 0101 loads the clear code from bits [1:0]. The codes are 00 for 0x0000, 01 for 0x8000, 10 for 0xFFFF and 11 for no action.
- R9: A falling edge of preset_n loads every input register and every DAC register with the clear-code value. The new values are visible after the third rising clock edge that samples preset_n low.
- R10: If the preset falls while write_busy is high, the next command strobe is discarded. The first strobe that is not discarded after that is applied normally.
- R11: Command codes that are not listed above change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_word | input | 32 | Assembled command word |
| cmd_valid | input | 1 | One-cycle strobe: cmd_word is complete |
| write_busy | input | 1 | Front end is shifting a word |
| xfer_n | input | 1 | Active-low transfer level |
| preset_n | input | 1 | Asynchronous active-low preset, falling-edge active |
| code_out | output | 128 | Channel codes, channel n at [16n+15:16n] |
| pd_mode | output | 16 | Drive modes, channel n at [2n+1:2n] |
| ref_on | output | 1 | Internal reference enable |

## Verification
The assertions check, on every cycle, the following: the mode that lands in each masked channel, that the DAC registers do not move under a power-down command, the full-scale preset load, and that a discarded strobe leaves the input registers untouched. They also check that the reference setting comes from bit 0 and that the reference drops when every channel is powered down at once. Some behaviours need a planned sequence of commands, so only the bench scenarios can show them. These are the choice of value on power-up under each transfer level, the recovery after an aborted write, the no-action clear code, and the reference coming back when a single channel powers up.

// File: rtl/dac_ctrl_core.sv
module dac_ctrl_core #(
  parameter int NCH = 8,
  parameter int DW  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [31:0]         cmd_word,
  input  logic                cmd_valid,
  input  logic                write_busy,
  input  logic                xfer_n,
  input  logic                preset_n,
  output logic [NCH*DW-1:0]   code_out,
  output logic [2*NCH-1:0]    pd_mode,
  output logic                ref_on
);
  localparam logic [3:0] OP_WR_IN  = 4'b0000;
  localparam logic [3:0] OP_UPD    = 4'b0001;
  localparam logic [3:0] OP_WR_UPD = 4'b0011;
  localparam logic [3:0] OP_PD     = 4'b0100;
  localparam logic [3:0] OP_CCODE  = 4'b0101;
  localparam logic [3:0] OP_REF    = 4'b1000;
  localparam logic [3:0] ADDR_ALL  = 4'b1111;

  logic [3:0]    op, addr;
  logic [DW-1:0] wdata;
  logic [1:0]    pdm;
  logic [NCH-1:0] mask;

  assign op    = cmd_word[27:24];
  assign addr  = cmd_word[23:20];
  assign wdata = cmd_word[4 +: DW];
  assign pdm   = cmd_word[9:8];
  assign mask  = cmd_word[NCH-1:0];

  logic [NCH-1:0][DW-1:0] inp_q, dac_q;
  logic [NCH-1:0][1:0]    pd_q;
  logic [NCH-1:0]         down;
  logic [1:0]             ccode_q;
  logic                   ref_q;
  logic                   s1, s2, s3, abort_q;
  logic                   fall, accept, clr_do;
  logic [DW-1:0]          clr_val;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= 3'b111;
    else        {s1, s2, s3} <= {preset_n, s1, s2};

  assign fall   = s3 & ~s2;
  assign accept = cmd_valid & ~abort_q & ~fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                               abort_q <= 1'b0;
    else if (fall && write_busy && !cmd_valid) abort_q <= 1'b1;
    else if (cmd_valid || !write_busy)         abort_q <= 1'b0;

  always_comb begin
    case (ccode_q)
      2'b01:   clr_val = {1'b1, {(DW-1){1'b0}}};
      2'b10:   clr_val = {DW{1'b1}};
      default: clr_val = '0;
    endcase
  end
  assign clr_do = fall && (ccode_q != 2'b11);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ccode_q <= 2'b00;
      ref_q   <= 1'b0;
    end else if (accept) begin
      if (op == OP_CCODE) ccode_q <= cmd_word[1:0];
      if (op == OP_REF)   ref_q   <= cmd_word[0];
    end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic          hit;
    logic [DW-1:0] inp_n, dac_n;

    assign hit = accept && (addr == 4'(i) || addr == ADDR_ALL);

    always_comb begin
      inp_n = inp_q[i];
      if (clr_do)                                      inp_n = clr_val;
      else if (hit && (op == OP_WR_IN || op == OP_WR_UPD)) inp_n = wdata;
    end

    always_comb begin
      dac_n = dac_q[i];
      if (clr_do)                      dac_n = clr_val;
      else if (!xfer_n)                dac_n = inp_n;
      else if (hit && op == OP_WR_UPD) dac_n = wdata;
      else if (hit && op == OP_UPD)    dac_n = inp_q[i];
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        inp_q[i] <= '0;
        dac_q[i] <= '0;
        pd_q[i]  <= 2'b00;
      end else begin
        inp_q[i] <= inp_n;
        dac_q[i] <= dac_n;
        if (accept && op == OP_PD && mask[i]) pd_q[i] <= pdm;
      end

    assign down[i]                = (pd_q[i] != 2'b00);
    assign code_out[i*DW +: DW]   = down[i] ? '0 : dac_q[i];
    assign pd_mode[2*i +: 2]      = pd_q[i];

    assert_pd_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op == OP_PD && mask[i]) |=> (pd_q[i] == $past(pdm)));

    assert_full_preset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && ccode_q == 2'b10) |=> (&dac_q[i] && &inp_q[i]));
  end

  assign ref_on = ref_q & ~(&down);

  assert_pd_keeps_dac_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_PD && xfer_n) |=> $stable(dac_q));

  assert_ref_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_REF) |=> (ref_q == $past(cmd_word[0])));

  assert_ref_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_PD && pdm != 2'b00 && &mask) |=> !ref_on);

  assert_abort_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && abort_q && !fall) |=> $stable(inp_q));
endmodule

// File: tb/tb_dac_ctrl_core.sv
module tb_dac_ctrl_core;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int DW  = 16;

  logic clk = 0, rst_n = 0;
  logic [31:0] cmd_word = '0;
  logic cmd_valid = 0, write_busy = 0, xfer_n = 1, preset_n = 1;
  logic [NCH*DW-1:0] code_out;
  logic [2*NCH-1:0]  pd_mode;
  logic ref_on;

  dac_ctrl_core #(.NCH(NCH), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_valid(cmd_valid),
    .write_busy(write_busy), .xfer_n(xfer_n), .preset_n(preset_n),
    .code_out(code_out), .pd_mode(pd_mode), .ref_on(ref_on));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          kind;
    int          ch;
    logic [15:0] val;
    string       req;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic expect_code(int ch, logic [15:0] v, string r);
    q.push_back('{0, ch, v, r});
  endtask
  task automatic expect_mode(int ch, logic [1:0] m, string r);
    q.push_back('{1, ch, 16'(m), r});
  endtask
  task automatic expect_ref(logic v, string r);
    q.push_back('{2, 0, 16'(v), r});
  endtask

  function automatic logic [31:0] mk(logic [3:0] op, logic [3:0] a, logic [15:0] d);
    return {4'h0, op, a, d, 4'h0};
  endfunction

  task automatic send(logic [31:0] w);
    @(negedge clk);
    cmd_word = w; cmd_valid = 1;
    @(posedge clk); #1;
    cmd_valid = 0;
  endtask

  task automatic fall_preset();
    @(negedge clk);
    preset_n = 0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic release_preset();
    @(negedge clk);
    preset_n = 1;
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      logic [15:0] act;
      e = q.pop_front();
      case (e.kind)
        0: act = code_out[e.ch*DW +: DW];
        1: act = 16'(pd_mode[e.ch*2 +: 2]);
        default: act = 16'(ref_on);
      endcase
      checks++;
      if (act !== e.val) begin
        fails++;
        $display("FAIL %s: kind %0d ch %0d actual %h expected %h", e.req, e.kind, e.ch, act, e.val);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    for (int c = 0; c < NCH; c++) begin
      expect_code(c, 16'h0000, "R1");
      expect_mode(c, 2'b00, "R1");
    end
    expect_ref(1'b0, "R1");

    send(mk(4'b0000, 4'd2, 16'h1234));
    expect_code(2, 16'h0000, "R2");
    send(mk(4'b0001, 4'd2, 16'h0000));
    expect_code(2, 16'h1234, "R2");
    send(mk(4'b0011, 4'hF, 16'h0F0F));
    for (int c = 0; c < NCH; c++) expect_code(c, 16'h0F0F, "R2");

    @(negedge clk); xfer_n = 0;
    send(mk(4'b0000, 4'd5, 16'hAAAA));
    expect_code(5, 16'hAAAA, "R3");
    @(negedge clk); xfer_n = 1;

    send(mk(4'b0000, 4'd1, 16'h5555));
    expect_code(1, 16'h0F0F, "R2");
    send({22'h0, 2'b10, 8'h03} | {4'h0, 4'b0100, 24'h0});
    expect_mode(0, 2'b10, "R4");
    expect_mode(1, 2'b10, "R4");
    expect_mode(2, 2'b00, "R4");
    expect_code(1, 16'h0000, "R4");
    send({22'h0, 2'b00, 8'h02} | {4'h0, 4'b0100, 24'h0});
    expect_code(1, 16'h0F0F, "R5");
    expect_mode(1, 2'b00, "R5");
    send(mk(4'b0000, 4'd0, 16'h7777));
    @(negedge clk); xfer_n = 0;
    send({22'h0, 2'b00, 8'h01} | {4'h0, 4'b0100, 24'h0});
    expect_code(0, 16'h7777, "R5");
    expect_code(1, 16'h5555, "R3");
    @(negedge clk); xfer_n = 1;

    send({4'h0, 4'b1000, 4'h0, 19'h7FFFF, 1'b1});
    expect_ref(1'b1, "R6");
    send({22'h0, 2'b11, 8'hFF} | {4'h0, 4'b0100, 24'h0});
    expect_ref(1'b0, "R7");
    expect_mode(6, 2'b11, "R4");
    send({22'h0, 2'b00, 8'h80} | {4'h0, 4'b0100, 24'h0});
    expect_ref(1'b1, "R7");
    send({4'h0, 4'b1000, 4'hF, 19'h7FFFF, 1'b0});
    expect_ref(1'b0, "R6");
    send({22'h0, 2'b00, 8'hFF} | {4'h0, 4'b0100, 24'h0});

    send(mk(4'b0111, 4'd0, 16'hDEAD));
    expect_code(0, 16'h7777, "R11");
    expect_ref(1'b0, "R11");

    fall_preset();
    for (int c = 0; c < NCH; c++) expect_code(c, 16'h0000, "R9");
    release_preset();

    send({4'h0, 4'b0101, 22'h0, 2'b01});
    fall_preset();
    expect_code(0, 16'h8000, "R8");
    expect_code(7, 16'h8000, "R9");
    release_preset();
    send(mk(4'b0011, 4'd3, 16'h1111));
    expect_code(3, 16'h1111, "R10");

    send({4'h0, 4'b0101, 22'h0, 2'b11});
    fall_preset();
    expect_code(3, 16'h1111, "R8");
    expect_code(0, 16'h8000, "R8");
    release_preset();

    send({4'h0, 4'b0101, 22'h0, 2'b10});
    @(negedge clk); write_busy = 1;
    fall_preset();
    expect_code(4, 16'hFFFF, "R9");
    send(mk(4'b0011, 4'd4, 16'h2222));
    @(negedge clk); write_busy = 0;
    expect_code(4, 16'hFFFF, "R10");
    release_preset();
    send(mk(4'b0011, 4'd4, 16'h3333));
    expect_code(4, 16'h3333, "R10");

    repeat (3) @(negedge clk);
    wait (q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule